// File: doc/BRIEF.md
# Single-cycle 16-bit processor core

This block is a compact processor that completes one 16-bit instruction every clock. The program counter indexes a word-addressed instruction store. The fetched word is decoded combinationally, its operands come from a sixteen-entry register file, and an adder/subtractor produces either an arithmetic result, a data-memory address or an equality test. Register-file and data-memory writes, and the program-counter update, all take effect on the same rising edge. The instruction set has six operations: register add, register subtract, load word, store word, branch-if-equal and absolute jump.

A loader port fills the program and data stores. It is normally used while reset is held. A debug port shows the program counter and any one register, so a test can run a program and then read back its results. Reset is asynchronous and active-low, and its release is synchronised inside the block. While the synchronised reset is active, the core changes no register and no memory word.

Top module: `rv16_core`

## Requirements
- R1: While reset is held, `pc_o` reads 0 and every register reads 0. A reset asserted in the middle of a program clears both the program counter and the registers.
- R2: Opcode 0000 (bits [15:12]) is ADD. It writes R[bits 3:0] = R[bits 11:8] + R[bits 7:4], wrapping modulo 2^16. The destination may be the same register as a source.
- R3: Opcode 0001 is SUB. It writes R[bits 3:0] = R[bits 11:8] − R[bits 7:4], wrapping modulo 2^16.
- R4: Every instruction other than a branch or a jump advances the program counter by exactly one word.
- R5: Opcode 1011 is LOAD. The address is R[bits 11:8] plus bits [3:0] sign-extended to 16 bits, and only the low 8 bits of that sum index memory. The word read is written into R[bits 7:4].
- R6: Opcode 1100 is STORE. It forms its address the same way as LOAD, writes R[bits 7:4] into data memory at that address, and changes no register.
- R7: Opcode 1101 is BEQ. When R[bits 11:8] equals R[bits 7:4], the next PC is PC+1 plus the sign-extended bits [3:0], and a negative offset branches backwards. Otherwise the next PC is PC+1.
- R8: Opcode 1110 is JMP. The next PC is the upper four bits of PC+1 joined with instruction bits [11:0].
- R9: Opcodes 0010–1010 and 1111 are no-ops. They change no register and no memory word, and they only advance the PC.
- R10: When `ld_imem_we` is high, `ld_data` is written into the instruction store at `ld_addr`. When `ld_dmem_we` is high, it is written into the data store at that address. While reset is active, a STORE at PC 0 does not modify data memory.
- R11: `dbg_data` shows, combinationally, the current value of the register selected by `dbg_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ld_imem_we | input | 1 | Write enable for the instruction store loader |
| ld_dmem_we | input | 1 | Write enable for the data store loader |
| ld_addr | input | MEM_AW | Loader word address |
| ld_data | input | 16 | Loader write data |
| pc_o | output | 16 | Current program counter |
| dbg_sel | input | 4 | Register index for the debug read port |
| dbg_data | output | 16 | Contents of the selected register |

## Verification
The assertions assume that the loader is not used while the core is running. A loader write to data memory would override a STORE in the same cycle, and a loader write to the instruction store would change the instruction being checked. The stimulus keeps within this by doing every loader write while `rst_n` is low, and by reading results only through the debug port. Each program ends in a jump-to-self, so the PC settles at a known address. Both stores hold 256 words, so every program stays below that size.

// File: rtl/rv16_pkg.sv
package rv16_pkg;
  localparam int XLEN = 16;
  localparam int NREG = 16;
  localparam int RIDX = $clog2(NREG);
  localparam int IMMW = 4;
  localparam int JMPW = 12;

  localparam logic [3:0] OPC_ADD  = 4'b0000;
  localparam logic [3:0] OPC_SUB  = 4'b0001;
  localparam logic [3:0] OPC_LOAD = 4'b1011;
  localparam logic [3:0] OPC_STOR = 4'b1100;
  localparam logic [3:0] OPC_BEQ  = 4'b1101;
  localparam logic [3:0] OPC_JMP  = 4'b1110;

  typedef struct packed {
    logic rf_we;
    logic dm_we;
    logic wb_mem;
    logic use_imm;
    logic alu_sub;
    logic is_beq;
    logic is_jmp;
  } ctrl_t;

  function automatic ctrl_t decode(input logic [3:0] opc);
    ctrl_t c;
    c = '0;
    unique case (opc)
      OPC_ADD:  c.rf_we = 1'b1;
      OPC_SUB:  begin c.rf_we = 1'b1; c.alu_sub = 1'b1; end
      OPC_LOAD: begin c.rf_we = 1'b1; c.wb_mem = 1'b1; c.use_imm = 1'b1; end
      OPC_STOR: begin c.dm_we = 1'b1; c.use_imm = 1'b1; end
      OPC_BEQ:  begin c.is_beq = 1'b1; c.alu_sub = 1'b1; end
      OPC_JMP:  c.is_jmp = 1'b1;
      default:  c = '0;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/rv16_alu.sv
module rv16_alu #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    y    = sub ? (a - b) : (a + b);
    zero = (y == '0);
  end
endmodule

// File: rtl/rv16_regfile.sv
module rv16_regfile #(
  parameter int W = 16,
  parameter int N = 16,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra_a,
  output logic [W-1:0]  rd_a,
  input  logic [AW-1:0] ra_b,
  output logic [W-1:0]  rd_b,
  input  logic [AW-1:0] ra_c,
  output logic [W-1:0]  rd_c
);
  logic [W-1:0] q [N];
  logic [N-1:0] en;

  for (genvar i = 0; i < N; i++) begin : g_reg
    always_comb en[i] = we && (wa == AW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q[i] <= '0;
      else if (en[i]) q[i] <= wd;
    end
  end

  always_comb begin
    rd_a = q[ra_a];
    rd_b = q[ra_b];
    rd_c = q[ra_c];
  end
endmodule

// File: rtl/rv16_ram.sv
module rv16_ram #(
  parameter int W  = 16,
  parameter int AW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra,
  output logic [W-1:0]  rd
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  always_comb rd = mem[ra];
endmodule

// File: rtl/rv16_core.sv
module rv16_core
  import rv16_pkg::*;
#(
  parameter int MEM_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_imem_we,
  input  logic              ld_dmem_we,
  input  logic [MEM_AW-1:0] ld_addr,
  input  logic [XLEN-1:0]   ld_data,
  output logic [XLEN-1:0]   pc_o,
  input  logic [RIDX-1:0]   dbg_sel,
  output logic [XLEN-1:0]   dbg_data
);
  localparam int HI = XLEN - JMPW;

  // reset: asynchronous assertion, two-stage synchronous release
  logic [1:0] rst_q;
  logic       run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign run = rst_q[1];

  logic [XLEN-1:0] pc_q, pc_d, pc_inc, br_tgt, jmp_tgt;
  logic [XLEN-1:0] instr, sext, rd_a, rd_b, alu_b, alu_y, dm_rd, wb_d;
  logic [RIDX-1:0] wb_a;
  logic            zero, rf_we, dm_core_we, dm_we;
  logic [MEM_AW-1:0] dm_wa;
  logic [XLEN-1:0]   dm_wd;
  ctrl_t ctl;

  rv16_ram #(.W(XLEN), .AW(MEM_AW)) u_imem (
    .clk(clk), .we(ld_imem_we), .wa(ld_addr), .wd(ld_data),
    .ra(pc_q[MEM_AW-1:0]), .rd(instr)
  );

  always_comb begin
    ctl  = decode(instr[15:12]);
    sext = {{(XLEN-IMMW){instr[IMMW-1]}}, instr[IMMW-1:0]};
    alu_b = ctl.use_imm ? sext : rd_b;
  end

  rv16_regfile #(.W(XLEN), .N(NREG)) u_rf (
    .clk(clk), .rst_n(run), .we(rf_we), .wa(wb_a), .wd(wb_d),
    .ra_a(instr[11:8]), .rd_a(rd_a),
    .ra_b(instr[7:4]),  .rd_b(rd_b),
    .ra_c(dbg_sel),     .rd_c(dbg_data)
  );

  rv16_alu #(.W(XLEN)) u_alu (
    .a(rd_a), .b(alu_b), .sub(ctl.alu_sub), .y(alu_y), .zero(zero)
  );

  always_comb begin
    dm_core_we = run && ctl.dm_we;
    dm_we      = ld_dmem_we || dm_core_we;
    dm_wa      = ld_dmem_we ? ld_addr : alu_y[MEM_AW-1:0];
    dm_wd      = ld_dmem_we ? ld_data : rd_b;
  end

  rv16_ram #(.W(XLEN), .AW(MEM_AW)) u_dmem (
    .clk(clk), .we(dm_we), .wa(dm_wa), .wd(dm_wd),
    .ra(alu_y[MEM_AW-1:0]), .rd(dm_rd)
  );

  always_comb begin
    rf_we = run && ctl.rf_we;
    wb_a  = ctl.wb_mem ? instr[7:4] : instr[3:0];
    wb_d  = ctl.wb_mem ? dm_rd : alu_y;
  end

  // next-state of the program counter
  always_comb begin
    pc_inc  = pc_q + XLEN'(1);
    br_tgt  = pc_inc + sext;
    jmp_tgt = {pc_inc[XLEN-1:XLEN-HI], instr[JMPW-1:0]};
    if (ctl.is_jmp)              pc_d = jmp_tgt;
    else if (ctl.is_beq && zero) pc_d = br_tgt;
    else                         pc_d = pc_inc;
  end

  always_ff @(posedge clk or negedge run) begin
    if (!run) pc_q <= '0;
    else      pc_q <= pc_d;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/rv16_core_chk.sv
module rv16_core_chk (
  input logic        clk,
  input logic        run,
  input logic [15:0] pc,
  input logic [15:0] instr,
  input logic [15:0] rd_a,
  input logic [15:0] rd_b,
  input logic        rf_we,
  input logic        dm_core_we
);
  logic [3:0]  opc;
  logic [15:0] off;
  logic        undef;

  always_comb begin
    opc   = instr[15:12];
    off   = {{12{instr[3]}}, instr[3:0]};
    undef = (opc > 4'b0001 && opc < 4'b1011) || opc == 4'b1111;
  end

  a_r4_step_one: assert property (@(posedge clk) disable iff (!run)
    (opc != 4'b1101 && opc != 4'b1110) |=> pc == $past(pc) + 16'd1);

  a_r7_beq_taken: assert property (@(posedge clk) disable iff (!run)
    (opc == 4'b1101 && rd_a == rd_b) |=> pc == $past(pc) + 16'd1 + $past(off));

  a_r7_beq_fall: assert property (@(posedge clk) disable iff (!run)
    (opc == 4'b1101 && rd_a != rd_b) |=> pc == $past(pc) + 16'd1);

  a_r8_jump: assert property (@(posedge clk) disable iff (!run)
    (opc == 4'b1110) |=> pc[11:0] == $past(instr[11:0]));

  a_r6_store_only_mem: assert property (@(posedge clk) disable iff (!run)
    (opc == 4'b1100) |-> (dm_core_we && !rf_we));

  a_r5_load_only_reg: assert property (@(posedge clk) disable iff (!run)
    (opc == 4'b1011) |-> (rf_we && !dm_core_we));

  a_r9_undef_quiet: assert property (@(posedge clk) disable iff (!run)
    undef |-> (!rf_we && !dm_core_we));
endmodule

bind rv16_core rv16_core_chk u_chk (
  .clk(clk), .run(run), .pc(pc_q), .instr(instr),
  .rd_a(rd_a), .rd_b(rd_b), .rf_we(rf_we), .dm_core_we(dm_core_we)
);

// File: tb/tb_rv16_core.sv
module tb_rv16_core;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ld_imem_we = 1'b0, ld_dmem_we = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [15:0]   ld_data = '0;
  logic [15:0]   pc_o, dbg_data;
  logic [3:0]    dbg_sel = '0;
  int checks = 0, errors = 0, cycles = 0;

  rv16_core #(.MEM_AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .ld_imem_we(ld_imem_we), .ld_dmem_we(ld_dmem_we),
    .ld_addr(ld_addr), .ld_data(ld_data), .pc_o(pc_o),
    .dbg_sel(dbg_sel), .dbg_data(dbg_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic put_i(input int a, input logic [15:0] d);
    @(negedge clk); ld_imem_we = 1'b1; ld_addr = AW'(a); ld_data = d;
    @(negedge clk); ld_imem_we = 1'b0;
  endtask

  task automatic put_d(input int a, input logic [15:0] d);
    @(negedge clk); ld_dmem_we = 1'b1; ld_addr = AW'(a); ld_data = d;
    @(negedge clk); ld_dmem_we = 1'b0;
  endtask

  task automatic hold_reset();
    @(negedge clk); rst_n = 1'b0;
  endtask

  task automatic go_until(input logic [15:0] halt, input string tag);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (pc_o == halt) break;
    end
    chk(tag, pc_o, halt);
  endtask

  task automatic reg_is(input int r, input logic [15:0] exp, input string tag);
    @(negedge clk); dbg_sel = 4'(r); #1;
    chk(tag, dbg_data, exp);
  endtask

  task automatic t_arith();
    hold_reset();
    put_d(0, 16'd5); put_d(1, 16'd7); put_d(2, 16'hFFFF);
    put_i(0, 16'hB010); put_i(1, 16'hB021); put_i(2, 16'hB032);
    put_i(3, 16'h0124); put_i(4, 16'h1125); put_i(5, 16'h0326);
    put_i(6, 16'h0111); put_i(7, 16'hE007);
    go_until(16'd7, "R4 sequential pc reaches halt");
    reg_is(4, 16'd12,   "R2 add");
    reg_is(5, 16'hFFFE, "R3 sub negative wrap");
    reg_is(6, 16'd6,    "R2 add wrap");
    reg_is(1, 16'd10,   "R2 dst equals src");
    reg_is(2, 16'd7,    "R11 debug read r2");
  endtask

  task automatic t_reset_mid();
    hold_reset();
    @(negedge clk); #1;
    chk("R1 pc cleared", pc_o, 16'd0);
    for (int r = 0; r < 16; r++) begin
      dbg_sel = 4'(r); #1;
      chk("R1 register cleared", dbg_data, 16'd0);
    end
  endtask

  task automatic t_mem();
    hold_reset();
    put_d(0, 16'd5); put_d(3, 16'h1234); put_d(4, 16'hABCD);
    put_d(12, 16'h0BAD); put_d(255, 16'h7777);
    put_i(0, 16'hB010); put_i(1, 16'hB023); put_i(2, 16'hC12F);
    put_i(3, 16'hB034); put_i(4, 16'hB147); put_i(5, 16'hB05F);
    put_i(6, 16'hE006);
    go_until(16'd6, "R4 memory program halts");
    reg_is(3, 16'h1234, "R6 store negative offset");
    reg_is(4, 16'h0BAD, "R5 load positive offset");
    reg_is(5, 16'h7777, "R5 address low bits wrap");
    reg_is(2, 16'h1234, "R6 store leaves registers");
  endtask

  task automatic t_branch();
    hold_reset();
    put_d(0, 16'd5); put_d(1, 16'd5); put_d(2, 16'd9);
    put_i(0, 16'hB010); put_i(1, 16'hB021); put_i(2, 16'hB032);
    put_i(3, 16'hD132); put_i(4, 16'hD122); put_i(5, 16'h0116);
    put_i(6, 16'h0116); put_i(7, 16'h0127); put_i(8, 16'h1717);
    put_i(9, 16'hD701); put_i(10, 16'hD00D); put_i(11, 16'hE00B);
    go_until(16'd11, "R7 branch program halts");
    reg_is(6, 16'd0, "R7 taken branch skips");
    reg_is(7, 16'd0, "R7 backward loop count");
  endtask

  task automatic t_jump_nop();
    hold_reset();
    put_d(0, 16'h0055);
    put_i(0, 16'hE005); put_i(1, 16'hB010); put_i(5, 16'hF111);
    put_i(6, 16'h2123); put_i(7, 16'hB020); put_i(8, 16'hE008);
    go_until(16'd8, "R8 jump program halts");
    reg_is(1, 16'd0,    "R8 jump skipped load");
    reg_is(3, 16'd0,    "R9 undefined opcode no write");
    reg_is(2, 16'h0055, "R9 execution resumes after no-op");
  endtask

  task automatic t_store_in_reset();
    hold_reset();
    put_d(0, 16'h4321);
    put_i(0, 16'hC000);
    repeat (5) @(negedge clk);
    put_i(0, 16'hB010); put_i(1, 16'hE001);
    go_until(16'd1, "R10 loader program halts");
    reg_is(1, 16'h4321, "R10 no store during reset");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_mid();
    t_arith();
    t_reset_mid();
    t_mem();
    t_branch();
    t_jump_nop();
    t_store_in_reset();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule